// File: doc/BRIEF.md
# Transmit Defer and Interframe-Gap Controller

This block tells an Ethernet MAC transmitter when it may begin a frame. After any activity on the medium it holds the transmitter off for a programmable interframe gap. The gap has two parts, each set by its own 8-bit input. In half duplex the block watches the PHY's carrier sense. Carrier that returns during the first part of the gap restarts the timer. Carrier during the second part is ignored, so that stations waiting for the medium get fair access. In full duplex carrier is ignored, and the gap is timed only from the end of the block's own transmission.

Carrier sense and collision from the PHY are asynchronous, and each passes through a two-flop synchronizer. A collision during transmission sends the controller into a jam hold state. A collision while the error line is active sends it into an error hold state. Both hold states last a fixed number of cycles, and the controller then returns to watching carrier. The block has three outputs: a deferring flag, a one-cycle pulse reporting that a frame had to wait, and the synchronized carrier sense.

The states and their codes are BEGIN=0, IDLE=1, JAM=2, ERROR=3, WAIT=4, GAP1=5, GAP2=6, CARRIER=7 and LATENCY=8. The transitions are:
- BEGIN always moves to CARRIER.
- CARRIER goes to JAM or ERROR on a collision while busy, goes to IDLE when busy, and goes to GAP2 once it is idle, carrier is low and the count is zero.
- IDLE goes to JAM or ERROR on a collision. It goes to GAP1 when busy falls with carrier low, or in burst mode. It goes to WAIT when busy falls with carrier high, and to CARRIER when carrier appears.
- WAIT goes to JAM or ERROR on a collision, and to GAP1 when carrier drops.
- GAP1 goes to ERROR on a collision with error, and to GAP2 at count zero.
- GAP2 goes to ERROR on a collision with error, and to LATENCY at count zero.
- LATENCY goes to JAM or ERROR on a collision, and to IDLE at count zero.
- JAM and ERROR go to CARRIER when the count is at or below one.
- Any other code returns to BEGIN.

Top module: `txgap_defer_ctrl`

## Requirements
- R1: `rst_n` is an asynchronous, active-low reset. During reset `defer_o`=1, `deferred_o`=0 and `crs_sync_o`=0. The first clock after reset moves BEGIN to CARRIER.
- R2: `crs_sync_o` equals `phy_crs` as it was two clock edges earlier. `phy_col` is synchronized through the same two-flop path before any state uses it.
- R3: `defer_o` is 0 in IDLE and 1 in every other state.
- R4: In IDLE with the transmitter not busy, the controller enters GAP1 in two cases: `tx_busy` fell on the previous edge while effective carrier is low, or effective burst is set. If `tx_busy` fell while carrier is high, it enters WAIT instead. WAIT enters GAP1 on the first edge that sees carrier low.
- R5: Entering GAP1 loads the counter with `gap_first`. The counter then decrements by one per clock, so GAP1 lasts `gap_first`+1 cycles and a setting of 0 passes through in one cycle. While in GAP1 with a nonzero count, synchronized carrier reloads `gap_first`.
- R6: Entering GAP2 loads `gap_second`, and carrier never changes GAP2's length. LATENCY then loads LAT_CYCLES and returns to IDLE when the count reaches zero.
- R7: With `half_dup`=0, synchronized carrier is treated as low in every state decision.
- R8: A synchronized collision while `tx_en` is high enters JAM. When `tx_en` is low and `tx_err` is high, a collision enters ERROR. In CARRIER both cases also need `tx_busy`, and GAP1 and GAP2 react only to the error case. JAM and ERROR load HOLD_CYCLES, stay that many cycles, then enter CARRIER.
- R9: CARRIER goes to IDLE whenever `tx_busy` is high and there is no collision. Entering CARRIER loads `gap_first`, carrier reloads it, and CARRIER enters GAP2 once the count is zero with `tx_busy` and carrier both low. IDLE enters CARRIER when carrier is high while idle with `tx_en` and `tx_err` low.
- R10: Burst mode counts only when `gig_mode`=1. With `gig_mode`=0, `burst_en` has no effect.
- R11: `deferred_o` pulses for one cycle, on the edge after `tx_busy` first rises, if `defer_o` was high in the cycle of the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gig_mode | input | 1 | 1000 Mb/s operation |
| half_dup | input | 1 | Half-duplex operation |
| burst_en | input | 1 | Burst mode request (gigabit only) |
| gap_first | input | 8 | Length of the restartable gap part, in cycles |
| gap_second | input | 8 | Length of the fixed gap part, in cycles |
| tx_busy | input | 1 | Local transmitter is sending |
| tx_en | input | 1 | Transmit enable toward the PHY |
| tx_err | input | 1 | Transmit error toward the PHY |
| phy_crs | input | 1 | Asynchronous carrier sense |
| phy_col | input | 1 | Asynchronous collision |
| defer_o | output | 1 | Transmission must wait |
| deferred_o | output | 1 | One-cycle pulse: a frame had to wait |
| crs_sync_o | output | 1 | Synchronized carrier sense |

## Verification
The embedded assertions check on every cycle the fixed relations that hold in any state. These are the two-edge carrier delay, the counter floor at zero, the carrier reload in GAP1, GAP2 holding until its count expires, hold-state exit to CARRIER, WAIT leaving on carrier loss, CARRIER yielding to a busy transmitter, and the pulse only following a deferring cycle. Only the bench scenarios can show the ordering effects. These include exact gap lengths for several settings including zero, restart versus no restart depending on which gap part sees carrier, full duplex ignoring carrier, and burst being ignored outside gigabit mode. They also include the collision paths ending back in a timed gap, which the bench follows with its cycle-accurate model.

// File: rtl/txgap_pkg.sv
package txgap_pkg;

    typedef enum logic [3:0] {
        ST_BEGIN   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_JAM     = 4'd2,
        ST_ERROR   = 4'd3,
        ST_WAIT    = 4'd4,
        ST_GAP1    = 4'd5,
        ST_GAP2    = 4'd6,
        ST_CARRIER = 4'd7,
        ST_LATENCY = 4'd8
    } defer_state_t;

    typedef enum logic [2:0] {
        CNT_DEC,
        CNT_LD_FIRST,
        CNT_LD_SECOND,
        CNT_LD_HOLD,
        CNT_LD_LAT
    } cnt_op_t;

endpackage

// File: rtl/txgap_sync.sv
module txgap_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= '0;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/txgap_counter.sv
module txgap_counter
    import txgap_pkg::*;
#(
    parameter int GAP_W       = 8,
    parameter int CNT_W       = 9,
    parameter int HOLD_CYCLES = 16,
    parameter int LAT_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_t          op,
    input  logic [GAP_W-1:0] gap_first,
    input  logic [GAP_W-1:0] gap_second,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYCLES);
    localparam logic [CNT_W-1:0] LAT_V  = CNT_W'(LAT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_LD_FIRST:  cnt_q <= CNT_W'(gap_first);
                CNT_LD_SECOND: cnt_q <= CNT_W'(gap_second);
                CNT_LD_HOLD:   cnt_q <= HOLD_V;
                CNT_LD_LAT:    cnt_q <= LAT_V;
                default:       if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            endcase
        end
    end

    assign cnt_o = cnt_q;

    // R5
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CNT_DEC && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/txgap_fsm.sv
module txgap_fsm
    import txgap_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gig_mode,
    input  logic             half_dup,
    input  logic             burst_en,
    input  logic [GAP_W-1:0] gap_first,
    input  logic             tx_busy,
    input  logic             tx_en,
    input  logic             tx_err,
    input  logic             crs_s,
    input  logic             col_s,
    input  logic [CNT_W-1:0] cnt,
    output cnt_op_t          op_o,
    output logic             defer_o,
    output logic             deferred_o
);

    defer_state_t state_q, state_d;
    logic         busy_del_q;
    logic         pulse_q;
    cnt_op_t      op_d;

    logic crs_e, burst_e, hit_en, hit_err, busy_fall, cnt_zero, cnt_low;

    assign crs_e     = half_dup & crs_s;
    assign burst_e   = burst_en & gig_mode;
    assign hit_en    = tx_en & col_s;
    assign hit_err   = tx_err & col_s;
    assign busy_fall = !tx_busy && busy_del_q;
    assign cnt_zero  = (cnt == '0);
    assign cnt_low   = (cnt <= CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_BEGIN;
            busy_del_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            busy_del_q <= tx_busy;
        end
    end

    // next state and counter command
    always_comb begin
        state_d = state_q;
        op_d    = CNT_DEC;
        unique case (state_q)
            ST_BEGIN: state_d = ST_CARRIER;
            ST_CARRIER: begin
                if (hit_en && tx_busy)        state_d = ST_JAM;
                else if (hit_err && tx_busy)  state_d = ST_ERROR;
                else if (tx_busy)             state_d = ST_IDLE;
                else if (!crs_e && cnt_zero)  state_d = ST_GAP2;
                else if (crs_e)               op_d    = CNT_LD_FIRST;
            end
            ST_JAM, ST_ERROR: begin
                if (cnt_low) state_d = ST_CARRIER;
            end
            ST_IDLE: begin
                if (hit_en)                                  state_d = ST_JAM;
                else if (hit_err)                            state_d = ST_ERROR;
                else if (tx_busy)                            state_d = ST_IDLE;
                else if ((busy_fall && !crs_e) || burst_e)   state_d = ST_GAP1;
                else if (busy_fall)                          state_d = ST_WAIT;
                else if (crs_e && !tx_en && !tx_err)         state_d = ST_CARRIER;
            end
            ST_WAIT: begin
                if (hit_en)       state_d = ST_JAM;
                else if (hit_err) state_d = ST_ERROR;
                else if (!crs_e)  state_d = ST_GAP1;
            end
            ST_GAP1: begin
                if (hit_err)       state_d = ST_ERROR;
                else if (cnt_zero) state_d = ST_GAP2;
                else if (crs_e)    op_d    = CNT_LD_FIRST;
            end
            ST_GAP2: begin
                if (hit_err)       state_d = ST_ERROR;
                else if (cnt_zero) state_d = ST_LATENCY;
            end
            ST_LATENCY: begin
                if (hit_en)        state_d = ST_JAM;
                else if (hit_err)  state_d = ST_ERROR;
                else if (cnt_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_BEGIN;
        endcase

        if (state_d != state_q) begin
            unique case (state_d)
                ST_GAP1, ST_CARRIER: op_d = CNT_LD_FIRST;
                ST_GAP2:             op_d = CNT_LD_SECOND;
                ST_LATENCY:          op_d = CNT_LD_LAT;
                ST_JAM, ST_ERROR:    op_d = CNT_LD_HOLD;
                default:             op_d = CNT_DEC;
            endcase
        end
    end

    assign op_o = op_d;

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= tx_busy && !busy_del_q && (state_q != ST_IDLE);
    end

    assign defer_o    = (state_q != ST_IDLE);
    assign deferred_o = pulse_q;

    // R5
    gap1_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP1 && crs_e && !cnt_zero && !hit_err)
        |=> (state_q == ST_GAP1 && cnt == CNT_W'($past(gap_first))));

    // R6
    gap2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP2 && !cnt_zero && !hit_err) |=> (state_q == ST_GAP2));

    // R8
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_JAM || state_q == ST_ERROR) && cnt == CNT_W'(1))
        |=> (state_q == ST_CARRIER));

    // R4
    wait_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !crs_e && !col_s) |=> (state_q == ST_GAP1));

    // R9
    carrier_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CARRIER && tx_busy && !col_s) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/txgap_defer_ctrl.sv
module txgap_defer_ctrl
    import txgap_pkg::*;
#(
    parameter int GAP_W       = 8,
    parameter int CNT_W       = 9,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16,
    parameter int LAT_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gig_mode,
    input  logic             half_dup,
    input  logic             burst_en,
    input  logic [GAP_W-1:0] gap_first,
    input  logic [GAP_W-1:0] gap_second,
    input  logic             tx_busy,
    input  logic             tx_en,
    input  logic             tx_err,
    input  logic             phy_crs,
    input  logic             phy_col,
    output logic             defer_o,
    output logic             deferred_o,
    output logic             crs_sync_o
);

    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] phy_sync;
    logic [CNT_W-1:0]  cnt;
    cnt_op_t           op;

    txgap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({phy_col, phy_crs}),
        .dout (phy_sync)
    );

    txgap_counter #(
        .GAP_W(GAP_W), .CNT_W(CNT_W),
        .HOLD_CYCLES(HOLD_CYCLES), .LAT_CYCLES(LAT_CYCLES)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .gap_first (gap_first),
        .gap_second(gap_second),
        .cnt_o     (cnt)
    );

    txgap_fsm #(.CNT_W(CNT_W), .GAP_W(GAP_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gig_mode  (gig_mode),
        .half_dup  (half_dup),
        .burst_en  (burst_en),
        .gap_first (gap_first),
        .tx_busy   (tx_busy),
        .tx_en     (tx_en),
        .tx_err    (tx_err),
        .crs_s     (phy_sync[0]),
        .col_s     (phy_sync[1]),
        .cnt       (cnt),
        .op_o      (op),
        .defer_o   (defer_o),
        .deferred_o(deferred_o)
    );

    assign crs_sync_o = phy_sync[0];

    // cycles since reset, saturating, so the delay check never reaches before reset
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R2
    crs_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && SYNC_STAGES == 2) |-> (crs_sync_o == $past(phy_crs, 2)));

    // R11
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deferred_o |-> $past(defer_o));

endmodule

// File: tb/test_txgap_defer_ctrl.sv
module test_txgap_defer_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HOLD = 16;
    localparam int LAT  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gig_mode = 1'b0, half_dup = 1'b1, burst_en = 1'b0;
    logic [7:0] gap_first = 8'd6, gap_second = 8'd3;
    logic tx_busy = 1'b0, tx_en = 1'b0, tx_err = 1'b0;
    logic phy_crs = 1'b0, phy_col = 1'b0;
    logic defer_o, deferred_o, crs_sync_o;

    always #2.5 clk = ~clk;   // 200 MHz

    txgap_defer_ctrl #(.HOLD_CYCLES(HOLD), .LAT_CYCLES(LAT)) i_txgap_defer_ctrl (
        .clk(clk), .rst_n(rst_n), .gig_mode(gig_mode), .half_dup(half_dup),
        .burst_en(burst_en), .gap_first(gap_first), .gap_second(gap_second),
        .tx_busy(tx_busy), .tx_en(tx_en), .tx_err(tx_err),
        .phy_crs(phy_crs), .phy_col(phy_col),
        .defer_o(defer_o), .deferred_o(deferred_o), .crs_sync_o(crs_sync_o)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit run = 1'b0;
    string tag = "R1";

    task automatic check(string t, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    // behavioural reference: state as plain integers (0 begin,1 idle,2 jam,3 error,
    // 4 wait,5 gap1,6 gap2,7 carrier,8 latency)
    int m_st, m_cnt;
    bit c1, c2, k1, k2, bd, m_pulse;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; c1 = 0; c2 = 0; k1 = 0; k2 = 0; bd = 0; m_pulse = 0;
        end else begin
            int ns, nc;
            bit ce, he, hr, bf, be, np;
            ce = half_dup && c2;
            he = tx_en && k2;
            hr = tx_err && k2;
            bf = !tx_busy && bd;
            be = burst_en && gig_mode;
            np = tx_busy && !bd && (m_st != 1);
            ns = m_st;
            nc = (m_cnt > 0) ? m_cnt - 1 : 0;
            if (m_st == 0) ns = 7;
            else if (m_st == 7) begin
                if (he && tx_busy) ns = 2;
                else if (hr && tx_busy) ns = 3;
                else if (tx_busy) ns = 1;
                else if (!ce && m_cnt == 0) ns = 6;
                else if (ce) nc = gap_first;
            end else if (m_st == 2 || m_st == 3) begin
                if (m_cnt <= 1) ns = 7;
            end else if (m_st == 1) begin
                if (he) ns = 2;
                else if (hr) ns = 3;
                else if (tx_busy) ns = 1;
                else if ((bf && !ce) || be) ns = 5;
                else if (bf) ns = 4;
                else if (ce && !tx_en && !tx_err) ns = 7;
            end else if (m_st == 4) begin
                if (he) ns = 2;
                else if (hr) ns = 3;
                else if (!ce) ns = 5;
            end else if (m_st == 5) begin
                if (hr) ns = 3;
                else if (m_cnt == 0) ns = 6;
                else if (ce) nc = gap_first;
            end else if (m_st == 6) begin
                if (hr) ns = 3;
                else if (m_cnt == 0) ns = 8;
            end else if (m_st == 8) begin
                if (he) ns = 2;
                else if (hr) ns = 3;
                else if (m_cnt == 0) ns = 1;
            end else ns = 0;
            if (ns != m_st) begin
                if (ns == 5 || ns == 7) nc = gap_first;
                else if (ns == 6) nc = gap_second;
                else if (ns == 8) nc = LAT;
                else if (ns == 2 || ns == 3) nc = HOLD;
            end
            c2 = c1; c1 = phy_crs; k2 = k1; k1 = phy_col; bd = tx_busy;
            m_st = ns; m_cnt = nc; m_pulse = np;
        end
    end

    always @(negedge clk) begin
        if (run && !done) begin
            check(tag, int'(defer_o), int'(m_st != 1));
            check("R11", int'(deferred_o), int'(m_pulse));
            check("R2", int'(crs_sync_o), int'(c2));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: values held during reset
        tick(3);
        check("R1", int'(defer_o), 1);
        check("R1", int'(deferred_o), 0);
        check("R1", int'(crs_sync_o), 0);
        run = 1'b1;
        rst_n = 1'b1;
        tick(1);
        check("R1", int'(defer_o), 1);
        tick(30);
        tag = "R3";
        check("R3", int'(defer_o), 0);

        // R4 / R5 / R6: own frame then full gap
        tag = "R4";
        tx_busy = 1'b1; tick(6);
        check("R11", int'(deferred_o), 0);
        tx_busy = 1'b0; tick(2);
        check("R5", int'(defer_o), 1);
        tick(25);

        // R11: new frame requested while still deferring
        tag = "R11";
        tx_busy = 1'b1; tick(4); tx_busy = 1'b0; tick(3);
        tx_busy = 1'b1; tick(3); tx_busy = 1'b0; tick(25);

        // R5: carrier during GAP1 restarts the timer
        tag = "R5";
        tx_busy = 1'b1; tick(3); tx_busy = 1'b0; tick(3);
        phy_crs = 1'b1; tick(4); phy_crs = 1'b0; tick(25);

        // R6: carrier during GAP2 is ignored
        tag = "R6";
        gap_first = 8'd2; gap_second = 8'd8;
        tx_busy = 1'b1; tick(3); tx_busy = 1'b0; tick(7);
        phy_crs = 1'b1; tick(2); phy_crs = 1'b0; tick(30);

        // R4: busy falls while carrier high -> WAIT, then GAP1 on carrier loss
        tag = "R4";
        gap_first = 8'd6; gap_second = 8'd3;
        tx_busy = 1'b1; tick(2); phy_crs = 1'b1; tick(4);
        tx_busy = 1'b0; tick(6);
        check("R4", int'(defer_o), 1);
        phy_crs = 1'b0; tick(30);

        // R9: carrier while idle -> CARRIER, busy -> IDLE, then timed gap
        tag = "R9";
        phy_crs = 1'b1; tick(5);
        check("R9", int'(defer_o), 1);
        tx_busy = 1'b1; tick(3);
        check("R9", int'(defer_o), 0);
        tx_busy = 1'b0; tick(3); phy_crs = 1'b0; tick(30);
        phy_crs = 1'b1; tick(4); phy_crs = 1'b0; tick(30);

        // R8: collision paths
        tag = "R8";
        tx_busy = 1'b1; tx_en = 1'b1; phy_col = 1'b1; tick(3);
        phy_col = 1'b0; tx_en = 1'b0; tx_busy = 1'b0; tick(45);
        tx_busy = 1'b1; tx_err = 1'b1; phy_col = 1'b1; tick(3);
        phy_col = 1'b0; tx_err = 1'b0; tx_busy = 1'b0; tick(45);
        tx_busy = 1'b1; tick(2); tx_busy = 1'b0; tick(4);
        tx_err = 1'b1; phy_col = 1'b1; tick(3);
        tx_err = 1'b0; phy_col = 1'b0; tick(45);

        // R7: full duplex ignores carrier
        tag = "R7";
        half_dup = 1'b0;
        for (int i = 0; i < 6; i++) begin
            phy_crs = ~phy_crs; tick(3);
        end
        phy_crs = 1'b1; tick(4);
        check("R7", int'(defer_o), 0);
        tx_busy = 1'b1; tick(3); tx_busy = 1'b0; tick(4);
        phy_crs = 1'b0; tick(4); phy_crs = 1'b1; tick(20);
        phy_crs = 1'b0; half_dup = 1'b1; tick(10);

        // R10: burst only in gigabit mode
        tag = "R10";
        burst_en = 1'b1; tick(10);
        check("R10", int'(defer_o), 0);
        gig_mode = 1'b1; tick(20);
        burst_en = 1'b0; tick(20);
        gig_mode = 1'b0;

        // R5: zero-length gap parts
        tag = "R5";
        gap_first = 8'd0; gap_second = 8'd0;
        tx_busy = 1'b1; tick(3); tx_busy = 1'b0; tick(10);
        gap_first = 8'd255; gap_second = 8'd1;
        tx_busy = 1'b1; tick(2); tx_busy = 1'b0; tick(270);

        // R1: reset in the middle of a gap
        tag = "R1";
        tx_busy = 1'b1; tick(2); tx_busy = 1'b0; tick(4);
        rst_n = 1'b0; tick(2);
        check("R1", int'(defer_o), 1);
        rst_n = 1'b1; tick(300);
        check("R3", int'(defer_o), 0);

        finish_run();
    end

endmodule